// File: doc/BRIEF.md
# Receive Byte Queue with Break Marking

This block holds the bytes a UART receiver has deserialized until software reads them. A deserializer offers a byte on a push port and only hands it over while the block signals that it can accept. Bus reads remove bytes through a pop strobe, oldest first. The queue holds exactly four entries.

A detected line break is handled as a special input. It latches a sticky break-change flag and places a zero byte into the queue. If the queue is already full, the zero byte goes into the newest slot in place of the byte that was there. A flush input, driven by the receiver-reset command, empties the queue. A clear input, driven by the reset-break-change command, drops the break flag. The block outputs the ready, full and break flags that the register block reports.

Top module: `rxq_fifo`

## Requirements
- R1: The queue holds at most four bytes and returns accepted bytes in arrival order.
- R2: `rx_ready` is high exactly when the queue holds at least one byte. `rx_full` is high exactly when it holds four. Both are registered state and update on the clock edge that changes the occupancy.
- R3: `pop_data` shows the oldest byte combinationally while the queue is non-empty. A `pop` at a clock edge removes that byte, which clears `rx_full`, and `rx_ready` falls when the last byte leaves.
- R4: While the queue is empty, `pop_data` reads 0x00, and a `pop` changes neither the occupancy nor the read order.
- R5: `can_accept` equals `rx_en` AND NOT `rx_full` AND NOT `brk_evt`. A `push_valid` while `can_accept` is low stores nothing. This holds even when a pop happens in the same cycle.
- R6: A `brk_evt` cycle makes `brk_flag` high at the next edge and stores a 0x00 byte whatever `rx_en` is. When the queue is full and no pop happens in that cycle, the 0x00 replaces the newest entry and the occupancy stays four.
- R7: `flush` empties the queue at the next edge, so `rx_ready` and `rx_full` go low. It overrides any push, break byte or pop in the same cycle, but a break in that cycle still sets `brk_flag`.
- R8: When a byte is stored and another is popped in the same cycle, the pop is served first. The occupancy is unchanged and both bytes reach their destinations.
- R9: `brk_flag` stays high until a cycle with `brk_clr` high and `brk_evt` low. If both are high in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; gates normal data |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | 8 | Offered byte |
| can_accept | output | 1 | A byte offered this cycle is stored |
| brk_evt | input | 1 | Line break detected (one cycle per event) |
| pop | input | 1 | Bus read of the receive data register |
| pop_data | output | 8 | Oldest byte, 0x00 when empty |
| flush | input | 1 | Receiver-reset command |
| brk_clr | input | 1 | Reset-break-change command |
| rx_ready | output | 1 | Queue non-empty |
| rx_full | output | 1 | Queue holds four bytes |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
`can_accept` and `pop_data` are combinational. They are sampled one time unit after the inputs change in mid-cycle, before the edge that acts on them. `rx_ready`, `rx_full` and `brk_flag` come from registers one edge after the stimulus. They are sampled one time unit after that edge, once the reference queue in the bench has applied the same cycle's inputs. Directed sequences (fill, overfill, full-queue break, empty pop, flush races, same-cycle pop with push) come first. A seeded random phase follows, and every cycle of it is compared the same way.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_DEPTH  = 4;

    typedef enum logic [1:0] {
        INS_NONE    = 2'd0,
        INS_APPEND  = 2'd1,
        INS_REPLACE = 2'd2
    } ins_e;

    // Decide where an incoming byte goes: a full queue with no pop in the
    // same cycle can only take a byte by overwriting its newest slot.
    function automatic ins_e pick_ins(input logic have, input logic full,
                                      input logic popping);
        if (!have)
            return INS_NONE;
        if (full && !popping)
            return INS_REPLACE;
        return INS_APPEND;
    endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = RXQ_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic             brk_evt,
    input  logic             pop,
    input  logic             flush,
    output logic             can_accept,
    output logic             empty,
    output logic             full,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr
);
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_nxt, wr_prv, rd_nxt;
    logic             data_ok, do_pop;
    ins_e             ins;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    assign can_accept = rx_en && !full && !brk_evt;
    assign data_ok    = push_valid && can_accept;
    assign do_pop     = pop && !empty && !flush;
    assign ins        = pick_ins((brk_evt || data_ok) && !flush, full, do_pop);

    assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    assign wr_prv = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
    assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

    assign wr_en   = (ins != INS_NONE);
    assign wr_addr = (ins == INS_REPLACE) ? wr_prv : wr_ptr;
    assign rd_addr = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count  <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= rd_nxt;
            if (ins == INS_APPEND)
                wr_ptr <= wr_nxt;
            count <= count + CNT_W'(ins == INS_APPEND) - CNT_W'(do_pop);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R1
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        full |-> !can_accept); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R7
    AST_IDLE_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !wr_en && !flush) |=> (empty && $stable(rd_ptr))); // R4
    AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (do_pop && ins == INS_APPEND) |=> $stable(count)); // R8
    AST_REPLACE_FULL: assert property (@(posedge clk) disable iff (rst)
        (ins == INS_REPLACE) |=> full); // R6
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (wr_en && wr_addr == PTR_W'(i))
                slot[i] <= wr_data;
        end
    end

    assign rd_data = slot[rd_addr];
endmodule

// File: rtl/rxq_brk.sv
module rxq_brk (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    AST_BRK_SETS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R6
    AST_BRK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R9
    AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R9
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = RXQ_DATA_W,
    parameter int DEPTH  = RXQ_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              can_accept,
    input  logic              brk_evt,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              flush,
    input  logic              brk_clr,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              brk_flag
);
    logic              empty, full, wr_en;
    logic [PTR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
        .brk_evt(brk_evt), .pop(pop), .flush(flush),
        .can_accept(can_accept), .empty(empty), .full(full),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr)
    );

    // A break always inserts a zero byte in place of line data.
    assign wr_data = brk_evt ? '0 : push_data;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rxq_brk u_brk (
        .clk(clk), .rst(rst), .set(brk_evt), .clr(brk_clr), .flag(brk_flag)
    );

    assign pop_data = empty ? '0 : rd_data;
    assign rx_ready = !empty;
    assign rx_full  = full;

    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_ready); // R2
endmodule

// File: tb/rxq_fifo_test.sv
`timescale 1ns/1ps
module rxq_fifo_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 0, push_valid = 0, brk_evt = 0, pop = 0, flush = 0, brk_clr = 0;
    logic [7:0] push_data = 0;
    logic can_accept, rx_ready, rx_full, brk_flag;
    logic [7:0] pop_data;

    int checks = 0, fails = 0;
    logic [7:0] mq [4];
    int mcnt = 0;
    bit mbrk = 0;

    always #4 clk = ~clk;

    rxq_fifo uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
        .push_data(push_data), .can_accept(can_accept), .brk_evt(brk_evt),
        .pop(pop), .pop_data(pop_data), .flush(flush), .brk_clr(brk_clr),
        .rx_ready(rx_ready), .rx_full(rx_full), .brk_flag(brk_flag)
    );

    function automatic logic [7:0] head_exp();
        return (mcnt == 0) ? 8'h00 : mq[0];
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit f, p, pv, input logic [7:0] d, input bit be, br, en);
        bit acc;
        acc = en && (mcnt != 4) && !be;
        if (be) mbrk = 1;
        else if (br) mbrk = 0;
        if (f) mcnt = 0;
        else begin
            if (p && mcnt > 0) begin
                for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (be) begin
                if (mcnt == 4) mq[3] = 8'h00;
                else begin mq[mcnt] = 8'h00; mcnt++; end
            end else if (pv && acc) begin
                mq[mcnt] = d; mcnt++;
            end
        end
    endtask

    task automatic cyc(input bit f, p, pv, input logic [7:0] d, input bit be, br, en);
        @(negedge clk);
        flush = f; pop = p; push_valid = pv; push_data = d;
        brk_evt = be; brk_clr = br; rx_en = en;
        #1;
        chk(8'(can_accept), 8'(en && mcnt != 4 && !be), "R5 can_accept");
        chk(pop_data, head_exp(), mcnt == 0 ? "R4 empty pop_data" : "R3 pop_data head");
        @(posedge clk);
        model_step(f, p, pv, d, be, br, en);
        #1;
        chk(8'(rx_ready), 8'(mcnt != 0), "R2 rx_ready");
        chk(8'(rx_full), 8'(mcnt == 4), "R2 rx_full");
        chk(8'(brk_flag), 8'(mbrk), "R9 brk_flag");
    endtask

    initial begin
        #(200000 * 8);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // reset state
        chk(8'(rx_ready), 8'h0, "R2 reset rx_ready");
        chk(8'(rx_full), 8'h0, "R2 reset rx_full");
        chk(8'(brk_flag), 8'h0, "R9 reset brk_flag");
        chk(8'(can_accept), 8'h0, "R5 reset can_accept with rx_en low");
        chk(pop_data, 8'h00, "R4 reset pop_data");

        // R5: data ignored while disabled
        cyc(0,0,1,8'h55,0,0,0);
        chk(8'(rx_ready), 8'h0, "R5 disabled push ignored");
        // R4: empty pop no effect
        cyc(0,1,0,8'h00,0,0,1);
        chk(pop_data, 8'h00, "R4 empty pop returns zero");
        // R1/R2: fill and overfill
        cyc(0,0,1,8'hA1,0,0,1);
        cyc(0,0,1,8'hA2,0,0,1);
        cyc(0,0,1,8'hA3,0,0,1);
        cyc(0,0,1,8'hA4,0,0,1);
        chk(8'(rx_full), 8'h1, "R2 full after four");
        cyc(0,0,1,8'hA5,0,0,1);
        // R5: full with pop, data still refused
        cyc(0,1,1,8'hA6,0,0,1);
        chk(8'(rx_full), 8'h0, "R3 pop clears full");
        chk(pop_data, 8'hA2, "R1 order after pop");
        // R8: pop and push together at count 3
        cyc(0,1,1,8'hB1,0,0,1);
        chk(8'(rx_full), 8'h0, "R8 count unchanged");
        chk(pop_data, 8'hA3, "R8 head advanced");
        cyc(0,0,1,8'hB2,0,0,1);
        // R6: break on full without pop replaces newest
        cyc(0,0,0,8'h00,1,0,1);
        chk(8'(brk_flag), 8'h1, "R6 break sets flag");
        chk(8'(rx_full), 8'h1, "R6 stays full");
        cyc(0,1,0,8'h00,0,0,1);
        chk(pop_data, 8'hA4, "R1 order A4");
        cyc(0,1,0,8'h00,0,0,1);
        chk(pop_data, 8'hB1, "R1 order B1");
        cyc(0,1,0,8'h00,0,0,1);
        chk(pop_data, 8'h00, "R6 replaced newest with zero");
        chk(8'(rx_ready), 8'h1, "R6 break byte present");
        cyc(0,1,0,8'h00,0,0,1);
        chk(8'(rx_ready), 8'h0, "R3 ready clears at empty");
        // R9: set wins over clear, then clear
        cyc(0,0,0,8'h00,1,1,0);
        chk(8'(brk_flag), 8'h1, "R9 set wins");
        chk(8'(rx_ready), 8'h1, "R6 break stored while disabled");
        cyc(0,0,0,8'h00,0,1,1);
        chk(8'(brk_flag), 8'h0, "R9 clear");
        // R7: flush with push, pop and break
        cyc(0,0,1,8'hC1,0,0,1);
        cyc(1,1,0,8'h00,1,0,1);
        chk(8'(rx_ready), 8'h0, "R7 flush empties");
        chk(8'(brk_flag), 8'h1, "R7 break flag set despite flush");
        cyc(0,0,1,8'hC2,0,0,1);
        cyc(1,0,1,8'hC3,0,0,1);
        chk(8'(rx_ready), 8'h0, "R7 flush overrides push");

        // random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            bit f, p, pv, be, br, en;
            f  = ($urandom % 40) == 0;
            p  = ($urandom % 5) < 2;
            pv = ($urandom % 2) == 1;
            be = ($urandom % 25) == 0;
            br = ($urandom % 10) == 0;
            en = ($urandom % 8) != 0;
            cyc(f, p, pv, 8'($urandom), be, br, en);
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule